// File: doc/BRIEF.md
# Non-Posted Completion Timeout Tracker

This block watches the requests a port issues toward a split-transaction link and remembers those that are owed an answer. Each request carries a kind code and a tag chosen by the requester. Posted kinds (memory writes and messages) pass straight through and are never tracked. Non-posted kinds occupy the entry of their tag until a matching completion returns. Read-like requests accept a completion with data or a data-less error completion. Write-like requests accept only a data-less completion. Several requests may be in flight at once, and their completions may come back in any order.

Every tracked entry holds a down-counter loaded from the programmed timeout value when its request is accepted. When the counter has run out, the entry is released and a one-cycle timeout event reports its tag. A run-time disable input freezes all counters and suppresses timeout events. A completion that matches no entry, or whose data presence the recorded request kind does not allow, raises a one-cycle unexpected-completion pulse and leaves the table untouched.

The request side is a valid/ready stream. A request transfers on a cycle where `req_valid` and `req_ready` are both high. The requester must hold kind and tag stable while `req_valid` is high and `req_ready` is low. Completions have no back-pressure: every cycle with `cpl_valid` high is consumed. Timeout, unexpected-completion, count and full outputs are plain status pins.

Top module: `cpl_watch`

## Requirements
- R1: Kind codes on `req_kind`: 0 memory read, 1 locked memory read, 2 I/O read, 3 config read type 0, 4 config read type 1 (read class, codes 0 to 4); 5 I/O write, 6 config write type 0, 7 config write type 1 (write class, codes 5 to 7); 8 memory write, 9 message, 10 message with data, and 11 to 15 are posted.
- R2: A posted request is always accepted (`req_ready` high), never allocates an entry and leaves `outstanding` unchanged.
- R3: A non-posted request is accepted only when its tag is not in use; the entry then counts in `outstanding` from the next cycle on.
- R4: A completion to a read-class entry, with or without data, releases the entry without an unexpected pulse.
- R5: A completion to a write-class entry releases it only when `cpl_has_data` is 0; with data, it is unexpected and the entry stays.
- R6: A completion to a tag not in use, or an illegal one (R5), gives `unexp_cpl` high for exactly the next cycle and changes no entry.
- R7: With timeout value N and detection enabled throughout, `timeout_valid` is high with `timeout_tag` equal to the tag in the cycle after the (N+1)th rising edge following the acceptance edge, and the entry is released at that edge.
- R8: With `timeout_disable` at 1 (reset value 0 means active), counters hold and no timeout event is raised; after return to 0, counting resumes from the held value.
- R9: If a legal completion and an expiry hit the same entry in the same cycle, the completion wins and no timeout is reported for it.
- R10: When several entries are expired at once, one timeout is reported per cycle, lowest tag first; the others keep waiting.
- R11: `full` is high exactly when all tags are in use; a non-posted request is then refused.
- R12: After reset no entry is in use, `outstanding` is 0, and `full`, `timeout_valid` and `unexp_cpl` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken this cycle |
| req_kind | input | 4 | Request kind code (R1) |
| req_tag | input | TAG_W (3) | Request tag |
| cpl_valid | input | 1 | Completion arriving this cycle |
| cpl_tag | input | TAG_W (3) | Tag carried by the completion |
| cpl_has_data | input | 1 | Completion carries data |
| timeout_value | input | TIMER_W (16) | Counter load value for new requests |
| timeout_disable | input | 1 | 1 freezes counters and suppresses timeouts |
| timeout_valid | output | 1 | One-cycle timeout event |
| timeout_tag | output | TAG_W (3) | Tag of the timed-out request |
| unexp_cpl | output | 1 | One-cycle unexpected-completion pulse |
| outstanding | output | TAG_W+1 (4) | Number of entries in use |
| full | output | 1 | All tags in use |

## Verification
Directed sequences separate the cases a random stream rarely lines up: a posted request beside a tracked one shows whether classification allocates; a write-class completion with data, then without, tells an illegal completion from a legal one; a zero timeout met by a same-cycle completion shows which side wins; two entries expiring together show the reporting order; a disable window placed mid-count shows the counters hold rather than restart. A table filled to every tag shows refusal and the full flag. A long random stream then mixes all kinds, tags, stray and legal completions, short timeout values and disable toggles, and is compared cycle by cycle against a bench model of the table.

// File: rtl/cpl_watch_pkg.sv
package cpl_watch_pkg;

  typedef enum logic [3:0] {
    KIND_MEM_RD    = 4'd0,
    KIND_MEM_RD_LK = 4'd1,
    KIND_IO_RD     = 4'd2,
    KIND_CFG_RD0   = 4'd3,
    KIND_CFG_RD1   = 4'd4,
    KIND_IO_WR     = 4'd5,
    KIND_CFG_WR0   = 4'd6,
    KIND_CFG_WR1   = 4'd7,
    KIND_MEM_WR    = 4'd8,
    KIND_MSG       = 4'd9,
    KIND_MSG_D     = 4'd10
  } req_kind_e;

  typedef struct packed {
    logic owes_cpl;      // a completion must come back
    logic data_allowed;  // completion may carry data
  } req_class_t;

endpackage

// File: rtl/cpl_req_classify.sv
module cpl_req_classify
  import cpl_watch_pkg::*;
(
  input  logic [3:0] kind,
  output req_class_t cls
);
  // R1: read class, write class, posted
  always_comb begin
    cls = '{owes_cpl: 1'b0, data_allowed: 1'b0};
    case (kind)
      KIND_MEM_RD, KIND_MEM_RD_LK, KIND_IO_RD, KIND_CFG_RD0, KIND_CFG_RD1:
        cls = '{owes_cpl: 1'b1, data_allowed: 1'b1};
      KIND_IO_WR, KIND_CFG_WR0, KIND_CFG_WR1:
        cls = '{owes_cpl: 1'b1, data_allowed: 1'b0};
      default:
        cls = '{owes_cpl: 1'b0, data_allowed: 1'b0};
    endcase
  end
endmodule

// File: rtl/cpl_tag_slot.sv
module cpl_tag_slot #(
  parameter int TIMER_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               load_data_ok,
  input  logic [TIMER_W-1:0] load_cnt,
  input  logic               release_i,
  input  logic               count_en,
  output logic               valid_o,
  output logic               data_ok_o,
  output logic               zero_o
);
  logic [TIMER_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o   <= 1'b0;
      data_ok_o <= 1'b0;
      cnt_q     <= '0;
    end else if (load) begin
      valid_o   <= 1'b1;
      data_ok_o <= load_data_ok;
      cnt_q     <= load_cnt;
    end else if (release_i) begin
      valid_o   <= 1'b0;
    end else if (valid_o && count_en && (cnt_q != '0)) begin
      cnt_q     <= cnt_q - 1'b1;
    end
  end

  assign zero_o = valid_o && (cnt_q == '0);
endmodule

// File: rtl/cpl_expire_pick.sv
module cpl_expire_pick #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]  cand,
  output logic [N-1:0]  grant,
  output logic [IW-1:0] idx,
  output logic          any
);
  // R10: lowest index wins
  always_comb begin
    grant = '0;
    idx   = '0;
    any   = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (cand[i] && !any) begin
        any      = 1'b1;
        grant[i] = 1'b1;
        idx      = IW'(i);
      end
    end
  end
endmodule

// File: rtl/cpl_watch.sv
module cpl_watch
  import cpl_watch_pkg::*;
#(
  parameter int NTAG    = 8,
  parameter int TIMER_W = 16,
  localparam int TAG_W  = (NTAG > 1) ? $clog2(NTAG) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [3:0]         req_kind,
  input  logic [TAG_W-1:0]   req_tag,
  input  logic               cpl_valid,
  input  logic [TAG_W-1:0]   cpl_tag,
  input  logic               cpl_has_data,
  input  logic [TIMER_W-1:0] timeout_value,
  input  logic               timeout_disable,
  output logic               timeout_valid,
  output logic [TAG_W-1:0]   timeout_tag,
  output logic               unexp_cpl,
  output logic [TAG_W:0]     outstanding,
  output logic               full
);
  req_class_t       cls;
  logic [NTAG-1:0]  slot_valid;
  logic [NTAG-1:0]  slot_dok;
  logic [NTAG-1:0]  slot_zero;
  logic [NTAG-1:0]  cand;
  logic [NTAG-1:0]  grant;
  logic [TAG_W-1:0] pick_idx;
  logic             pick_any;
  logic             issue;
  logic             cpl_hit;
  logic             cpl_bad;

  cpl_req_classify u_cls (
    .kind (req_kind),
    .cls  (cls)
  );

  // R2/R3: posted kinds always pass, tracked kinds need a free tag
  assign req_ready = !cls.owes_cpl || !slot_valid[req_tag];
  assign issue     = req_valid && req_ready && cls.owes_cpl;

  // R4/R5/R6: completion legality against the recorded class
  assign cpl_hit = cpl_valid && slot_valid[cpl_tag] &&
                   (slot_dok[cpl_tag] || !cpl_has_data);
  assign cpl_bad = cpl_valid && !cpl_hit;

  genvar g;
  generate
    for (g = 0; g < NTAG; g++) begin : g_slot
      logic hit_here;
      assign hit_here = cpl_hit && (cpl_tag == TAG_W'(g));
      // R9: a completion masks the expiry of its own entry
      assign cand[g]  = slot_zero[g] && !timeout_disable && !hit_here;

      cpl_tag_slot #(.TIMER_W(TIMER_W)) u_slot (
        .clk          (clk),
        .rst_n        (rst_n),
        .load         (issue && (req_tag == TAG_W'(g))),
        .load_data_ok (cls.data_allowed),
        .load_cnt     (timeout_value),
        .release_i    (hit_here || grant[g]),
        .count_en     (!timeout_disable),
        .valid_o      (slot_valid[g]),
        .data_ok_o    (slot_dok[g]),
        .zero_o       (slot_zero[g])
      );
    end
  endgenerate

  cpl_expire_pick #(.N(NTAG), .IW(TAG_W)) u_pick (
    .cand  (cand),
    .grant (grant),
    .idx   (pick_idx),
    .any   (pick_any)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      timeout_valid <= 1'b0;
      timeout_tag   <= '0;
      unexp_cpl     <= 1'b0;
    end else begin
      timeout_valid <= pick_any;
      timeout_tag   <= pick_idx;
      unexp_cpl     <= cpl_bad;
    end
  end

  always_comb begin
    outstanding = '0;
    for (int i = 0; i < NTAG; i++)
      outstanding = outstanding + (TAG_W+1)'(slot_valid[i]);
  end

  assign full = &slot_valid;
endmodule

// File: rtl/cpl_watch_chk.sv
module cpl_watch_chk #(
  parameter int NTAG    = 8,
  parameter int TIMER_W = 16,
  localparam int TAG_W  = (NTAG > 1) ? $clog2(NTAG) : 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_ready,
  input logic [3:0]         req_kind,
  input logic               timeout_disable,
  input logic               timeout_valid,
  input logic [TAG_W:0]     outstanding,
  input logic               full
);
  assert_posted_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind >= 4'd8) |-> req_ready);

  assert_full_refuse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (full && req_valid && req_kind < 4'd8) |-> !req_ready);

  assert_full_count_R11: assert property (@(posedge clk) disable iff (!rst_n)
    full == (outstanding == (TAG_W+1)'(NTAG)));

  assert_count_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    outstanding <= (TAG_W+1)'(NTAG));

  assert_disable_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_disable |=> !timeout_valid);

  assert_timeout_had_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_valid |-> ($past(outstanding) != '0));
endmodule

bind cpl_watch cpl_watch_chk #(.NTAG(NTAG), .TIMER_W(TIMER_W)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .req_valid       (req_valid),
  .req_ready       (req_ready),
  .req_kind        (req_kind),
  .timeout_disable (timeout_disable),
  .timeout_valid   (timeout_valid),
  .outstanding     (outstanding),
  .full            (full)
);

// File: tb/sim_cpl_watch.sv
module sim_cpl_watch;
  localparam int CLK_PERIOD = 10;
  localparam int NTAG       = 8;
  localparam int TIMER_W    = 16;
  localparam int TAG_W      = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [3:0] req_kind = '0;
  logic [TAG_W-1:0] req_tag = '0;
  logic cpl_valid = 1'b0, cpl_has_data = 1'b0;
  logic [TAG_W-1:0] cpl_tag = '0;
  logic [TIMER_W-1:0] timeout_value = '0;
  logic timeout_disable = 1'b0;
  logic timeout_valid, unexp_cpl, full;
  logic [TAG_W-1:0] timeout_tag;
  logic [TAG_W:0] outstanding;

  always #(CLK_PERIOD/2) clk = ~clk;

  cpl_watch #(.NTAG(NTAG), .TIMER_W(TIMER_W)) u0 (.*);

  int checks = 0, fails = 0, cyc = 0;
  string phase = "R12";

  // bench model of the table, built from the requirements
  bit mv[NTAG];
  bit mrd[NTAG];
  int mcnt[NTAG];
  bit e_tov, e_unx;
  int e_tag;

  function automatic bit owes(input logic [3:0] k);   // R1
    return k <= 4'd7;
  endfunction
  function automatic bit rd_class(input logic [3:0] k); // R1
    return k <= 4'd4;
  endfunction
  function automatic bit m_ready();
    return !owes(req_kind) || !mv[req_tag];
  endfunction
  function automatic int m_count();
    int c = 0;
    for (int i = 0; i < NTAG; i++) c += int'(mv[i]);
    return c;
  endfunction

  task automatic model_step();
    bit cl[NTAG];
    bit found = 0;
    bit rdy = m_ready();
    e_unx = 0;
    for (int i = 0; i < NTAG; i++) cl[i] = 0;
    if (cpl_valid) begin
      if (mv[cpl_tag] && (mrd[cpl_tag] || !cpl_has_data)) cl[cpl_tag] = 1;
      else e_unx = 1;
    end
    if (!timeout_disable)
      for (int i = 0; i < NTAG; i++)
        if (mv[i] && mcnt[i] == 0 && !cl[i] && !found) begin
          found = 1; cl[i] = 1; e_tag = i;
        end
    e_tov = found;
    for (int i = 0; i < NTAG; i++) begin
      if (cl[i]) mv[i] = 0;
      else if (mv[i] && !timeout_disable && mcnt[i] > 0) mcnt[i]--;
    end
    if (req_valid && rdy && owes(req_kind)) begin
      mv[req_tag] = 1; mrd[req_tag] = rd_class(req_kind);
      mcnt[req_tag] = int'(timeout_value);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NTAG; i++) begin mv[i] = 0; mcnt[i] = 0; mrd[i] = 0; end
      e_tov = 0; e_unx = 0; e_tag = 0;
    end else model_step();
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s [%s] actual=%0d expected=%0d at cycle %0d", req, phase, act, exp, cyc);
    end
  endtask

  task automatic compare_all();
    chk("R3 req_ready", int'(req_ready), int'(m_ready()));
    chk("R11 full", int'(full), int'(m_count() == NTAG));
    chk("R2 outstanding", int'(outstanding), m_count());
    chk("R7 timeout_valid", int'(timeout_valid), int'(e_tov));
    if (e_tov) chk("R10 timeout_tag", int'(timeout_tag), e_tag);
    chk("R6 unexp_cpl", int'(unexp_cpl), int'(e_unx));
  endtask

  task automatic tick();
    @(negedge clk);
    compare_all();
    req_valid = 0; cpl_valid = 0;
  endtask

  task automatic issue(input int k, input int t, input int to);
    req_valid = 1; req_kind = 4'(k); req_tag = TAG_W'(t); timeout_value = TIMER_W'(to);
    tick();
  endtask

  task automatic cpl(input int t, input bit d);
    cpl_valid = 1; cpl_tag = TAG_W'(t); cpl_has_data = d;
    tick();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic summary();
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog (all requirements) actual=%0d expected=<150000", cyc);
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    phase = "R12 reset"; tick();

    phase = "R1 R2 posted";
    issue(9, 0, 3); issue(8, 1, 3); issue(10, 2, 3); issue(13, 3, 3); idle(5);

    phase = "R7 timeout";
    issue(0, 2, 4); idle(8);

    phase = "R5 write class";
    issue(5, 1, 100); cpl(1, 1); cpl(1, 0); idle(2);

    phase = "R4 read class";
    issue(3, 4, 100); issue(1, 5, 100); cpl(5, 1); cpl(4, 0); idle(2);

    phase = "R6 stray";
    cpl(6, 0); cpl(7, 1); idle(2);

    phase = "R9 same cycle";
    issue(2, 5, 0); cpl(5, 1); idle(3);

    phase = "R10 order";
    issue(6, 6, 3); issue(0, 4, 2); idle(8);

    phase = "R8 disable";
    issue(4, 3, 3); idle(1); timeout_disable = 1; idle(10);
    timeout_disable = 0; idle(6);

    phase = "R11 full";
    for (int t = 0; t < NTAG; t++) issue(t % 8, t, 300);
    issue(0, 3, 5); issue(6, 0, 5); issue(9, 2, 5);
    cpl(3, 0); cpl(3, 1); idle(1);
    issue(2, 3, 5); idle(320);

    phase = "R3 R7 R8 R10 random";
    for (int n = 0; n < 5000; n++) begin
      if ($urandom % 40 == 0) timeout_disable = !timeout_disable;
      req_valid = ($urandom % 3) != 0;
      req_kind = 4'($urandom % 16);
      req_tag = TAG_W'($urandom);
      timeout_value = TIMER_W'($urandom % 24);
      cpl_valid = ($urandom % 3) == 0;
      cpl_tag = TAG_W'($urandom);
      cpl_has_data = 1'($urandom);
      if ($urandom % 2 == 0)
        for (int i = 0; i < NTAG; i++)
          if (mv[(int'(cpl_tag) + i) % NTAG]) begin
            cpl_tag = TAG_W'((int'(cpl_tag) + i) % NTAG);
            break;
          end
      tick();
    end
    timeout_disable = 0;
    idle(40);

    summary();
    $finish;
  end
endmodule